// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a bus-mastering network controller. A MAC-side byte stream delivers frames one byte per accepted beat. The engine places those bytes into host memory buffers, which a ring of small descriptors describes. Before it uses a descriptor, the engine reads the descriptor's ownership bit. It then streams the frame bytes into that descriptor's buffer. When a buffer fills before the frame ends, the engine chains into the next descriptor. At the end of the frame it writes the byte count and the status back to host memory and hands the descriptor back to the host.

The host prepares each descriptor in the ring before handing it to the engine:

- The descriptor lives in an 8-byte slot located at `ring_base + 8*index`.
- The 16-bit word at offset 0 holds the buffer's byte address.
- The word at offset 4 holds the buffer capacity as a negative count with its top nibble forced to ones.
- The host sets the ownership bit to give the slot to the engine.

The engine reports completion through a flag byte at offset 3 and a message-length word at offset 6. The MAC supplies the frame-check and framing error indications together with the last byte of each frame. The ring holds a power-of-two number of slots, encoded in the top three bits of a ring-length configuration word.

Top module: `rxr_engine`

## Requirements
- R1: After a synchronous reset, `rint`, `miss`, `rx_ready` and `mem_en` are low, and the first frame is placed through descriptor 0.
- R2: Descriptor `i` sits at byte address `ring_base + 8*i`, and the engine leaves the buffer-address word (offset 0) and the capacity word (offset 4) unchanged. The flag byte is the high byte of the word at offset 2, and the message-length word is at offset 6. All word accesses use even addresses.
- R3: A frame that fits one buffer leaves that descriptor's flag byte at 0x03. This means OWN (bit 7) is clear, STP (bit 1) is set and ENP (bit 0) is set. The message-length word holds the frame byte count in bits 11..0 with bits 15..12 zero. The engine writes the length word before it writes the flag byte.
- R4: Byte k of the data stored through a descriptor lands at buffer address + k. Even addresses use bus lane 7..0 and odd addresses use lane 15..8.
- R5: A frame-check error flagged with the last byte sets CRC (bit 3), and a framing error sets FRAM (bit 5). Either one also sets ERR (bit 6) in the final descriptor.
- R6: A frame that overflows its buffer continues in the next descriptor. The first descriptor gets STP only (0x02), with no error bits. The last descriptor gets ENP, any error bits, and the total frame length. A descriptor in the middle gets neither STP nor ENP.
- R7: The descriptor index advances once per released descriptor and wraps to 0 after `2^ring_len[15:13] - 1`.
- R8: If the current descriptor is host-owned when a frame starts, `miss` pulses for one cycle. The engine still consumes every byte of the frame, writes nothing to memory, raises no `rint`, and leaves the index unchanged.
- R9: If chaining reaches a host-owned descriptor, the current descriptor is closed with ENP, BUFF (bit 2), OFLO (bit 4) and ERR set, and its length equals the bytes stored so far. The remaining bytes are discarded, and the index then points at the host-owned descriptor.
- R10: `rint` is a single-cycle pulse. It rises in the cycle after the flag byte of an ENP descriptor is written, once per completed or truncated frame.
- R11: In every flag byte the engine writes, ERR is set exactly when at least one of BUFF, CRC, OFLO or FRAM is set.
- R12: `rx_ready` is high only while the engine can take a byte, and never in a cycle where the engine reads a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_len | input | 16 | Ring-length word; bits 15..13 hold log2 of the slot count |
| rx_valid | input | 1 | A stream byte is offered |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | The offered byte ends the frame |
| rx_crc_err | input | 1 | Frame-check error, meaningful with `rx_last` |
| rx_fram_err | input | 1 | Framing error, meaningful with `rx_last` |
| rx_ready | output | 1 | The engine accepts the offered byte this cycle |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_be | output | 2 | Byte lane enables |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| rint | output | 1 | Frame-complete pulse |
| miss | output | 1 | Missed-frame pulse |

## Verification
The assertions assume a memory that accepts every request at once and returns read data exactly one cycle later. They also assume that the ring-length order stays constant while frames are in flight. The bench's memory model follows that one-cycle read timing and never stalls. The bench changes descriptors only while the engine is idle between frames and re-arms slots only after their completion has been observed. It holds `ring_base` and `ring_len` fixed for the whole run. The error inputs are raised only on the beat that carries `rx_last`, so every beat keeps within what the error checks expect.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // flag byte bit positions (decoded by host software)
  localparam int F_ENP  = 0;
  localparam int F_STP  = 1;
  localparam int F_BUFF = 2;
  localparam int F_CRC  = 3;
  localparam int F_OFLO = 4;
  localparam int F_FRAM = 5;
  localparam int F_ERR  = 6;
  localparam int F_OWN  = 7;

  // byte offsets inside one 8-byte descriptor slot
  localparam int OFS_BUF  = 0;
  localparam int OFS_FLAG = 2;
  localparam int OFS_BLEN = 4;
  localparam int OFS_MLEN = 6;
  localparam int SLOT_SH  = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_RDF, S_CHK, S_WBM, S_RDA, S_RDL, S_LEN,
    S_DATA, S_WBL, S_WBF, S_DROP
  } rx_state_t;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [2:0]        order,
  input  logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] cur_slot,
  output logic [ADDR_W-1:0] nxt_slot
);
  import rxr_pkg::*;

  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] nxt_idx;

  always_comb begin
    for (int i = 0; i < IDX_W; i++) mask[i] = (i < int'(order));
  end

  assign nxt_idx  = (idx + IDX_W'(1)) & mask;
  assign cur_slot = base + (ADDR_W'(idx) << SLOT_SH);
  assign nxt_slot = base + (ADDR_W'(nxt_idx) << SLOT_SH);

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (advance) idx <= nxt_idx;
  end
endmodule

// File: rtl/rxr_flag_pack.sv
module rxr_flag_pack (
  input  logic       first,
  input  logic       last,
  input  logic       crc,
  input  logic       fram,
  input  logic       ovf,
  output logic [7:0] flags
);
  import rxr_pkg::*;

  logic crc_e, fram_e;
  assign crc_e  = last & ~ovf & crc;
  assign fram_e = last & ~ovf & fram;

  always_comb begin
    flags         = 8'h00;
    flags[F_STP]  = first;
    flags[F_ENP]  = last;
    flags[F_CRC]  = crc_e;
    flags[F_FRAM] = fram_e;
    flags[F_OFLO] = last & ovf;
    flags[F_BUFF] = last & ovf;
    flags[F_ERR]  = crc_e | fram_e | (last & ovf);
    flags[F_OWN]  = 1'b0;
  end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [15:0]       ring_len,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_crc_err,
  input  logic              rx_fram_err,
  output logic              rx_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rint,
  output logic              miss
);
  import rxr_pkg::*;

  localparam int WORD_W = 16;

  rx_state_t         st;
  logic              chain, first, ovf_q, crc_q, fram_q;
  logic [ADDR_W-1:0] wptr;
  logic [LEN_W-1:0]  remain, total;
  logic              rint_q, miss_q;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] cur_slot, nxt_slot;
  logic              advance;
  logic [7:0]        flags;
  logic              own_in;
  logic [WORD_W-1:0] neg_len;
  logic              unused_cfg;

  assign unused_cfg = ^{ring_len[12:0], idx};
  assign advance    = (st == S_WBM) || (st == S_WBF);
  assign own_in     = mem_rdata[8 + F_OWN];
  assign neg_len    = ~mem_rdata + WORD_W'(1);

  rxr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .advance(advance), .order(ring_len[15:13]),
    .base(ring_base), .idx(idx), .cur_slot(cur_slot), .nxt_slot(nxt_slot)
  );

  rxr_flag_pack u_flags (
    .first(first), .last(st == S_WBF), .crc(crc_q), .fram(fram_q),
    .ovf(ovf_q), .flags(flags)
  );

  // memory request decode from current state
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 2'b11;
    mem_addr  = cur_slot;
    mem_wdata = '0;
    rx_ready  = (st == S_DATA) || (st == S_DROP);
    unique case (st)
      S_RDF: begin
        mem_en   = 1'b1;
        mem_addr = (chain ? nxt_slot : cur_slot) + ADDR_W'(OFS_FLAG);
      end
      S_RDA: begin
        mem_en   = 1'b1;
        mem_addr = cur_slot + ADDR_W'(OFS_BUF);
      end
      S_RDL: begin
        mem_en   = 1'b1;
        mem_addr = cur_slot + ADDR_W'(OFS_BLEN);
      end
      S_DATA: begin
        mem_en    = rx_valid;
        mem_we    = 1'b1;
        mem_be    = wptr[0] ? 2'b10 : 2'b01;
        mem_addr  = wptr;
        mem_wdata = {rx_data, rx_data};
      end
      S_WBL: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_slot + ADDR_W'(OFS_MLEN);
        mem_wdata = WORD_W'(total);
      end
      S_WBM, S_WBF: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 2'b10;
        mem_addr  = cur_slot + ADDR_W'(OFS_FLAG);
        mem_wdata = {flags, 8'h00};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      chain  <= 1'b0;
      first  <= 1'b0;
      ovf_q  <= 1'b0;
      crc_q  <= 1'b0;
      fram_q <= 1'b0;
      wptr   <= '0;
      remain <= '0;
      total  <= '0;
      rint_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      rint_q <= (st == S_WBF);
      miss_q <= (st == S_CHK) && !chain && !own_in;
      unique case (st)
        S_IDLE: if (rx_valid) begin
          total  <= '0;
          first  <= 1'b1;
          chain  <= 1'b0;
          ovf_q  <= 1'b0;
          crc_q  <= 1'b0;
          fram_q <= 1'b0;
          st     <= S_RDF;
        end
        S_RDF: st <= S_CHK;
        S_CHK: begin
          if (chain) begin
            if (own_in) st <= S_WBM;
            else begin
              ovf_q <= 1'b1;
              st    <= S_WBL;
            end
          end else begin
            st <= own_in ? S_RDA : S_DROP;
          end
        end
        S_WBM: begin
          first <= 1'b0;
          chain <= 1'b0;
          st    <= S_RDA;
        end
        S_RDA: st <= S_RDL;
        S_RDL: begin
          wptr <= ADDR_W'(mem_rdata);
          st   <= S_LEN;
        end
        S_LEN: begin
          remain <= neg_len[LEN_W-1:0];
          st     <= S_DATA;
        end
        S_DATA: if (rx_valid) begin
          wptr   <= wptr + ADDR_W'(1);
          total  <= total + LEN_W'(1);
          remain <= remain - LEN_W'(1);
          if (rx_last) begin
            crc_q  <= rx_crc_err;
            fram_q <= rx_fram_err;
            st     <= S_WBL;
          end else if (remain == LEN_W'(1)) begin
            chain <= 1'b1;
            st    <= S_RDF;
          end
        end
        S_WBL: st <= S_WBF;
        S_WBF: st <= ovf_q ? S_DROP : S_IDLE;
        S_DROP: if (rx_valid && rx_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rint = rint_q;
  assign miss = miss_q;
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_ready,
  input logic              mem_en,
  input logic              mem_we,
  input logic [1:0]        mem_be,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              rint,
  input logic              miss
);
  logic flag_wr;
  assign flag_wr = mem_en && mem_we && (mem_be == 2'b10) && mem_addr[0] == 1'b0
                   && !rx_ready;

  assert_flag_own_clear_R3: assert property (@(posedge clk) disable iff (rst)
    flag_wr |-> !mem_wdata[15]);

  assert_err_summary_R11: assert property (@(posedge clk) disable iff (rst)
    flag_wr |-> (mem_wdata[14] == (mem_wdata[13] | mem_wdata[12] | mem_wdata[11] | mem_wdata[10])));

  assert_rint_after_enp_R10: assert property (@(posedge clk) disable iff (rst)
    rint |-> $past(flag_wr && mem_wdata[8]));

  assert_rint_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rint |=> !rint);

  assert_no_read_when_ready_R12: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !(mem_en && !mem_we));

  assert_word_align_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_be == 2'b11) |-> !mem_addr[0]);

  assert_miss_no_rint_R8: assert property (@(posedge clk) disable iff (rst)
    miss |-> !rint);
endmodule

bind rxr_engine rxr_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready), .mem_en(mem_en), .mem_we(mem_we),
  .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rint(rint), .miss(miss)
);

// File: tb/sim_rxr_engine.sv
module sim_rxr_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ring_base = 16'h0100;
  logic [15:0] ring_len  = 16'h4000;  // order 2 -> 4 slots
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0, rx_fram_err = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready, mem_en, mem_we, rint, miss;
  logic [1:0]  mem_be;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'h0000;

  always #4 clk = ~clk;

  rxr_engine u0 (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_len(ring_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_err(rx_crc_err), .rx_fram_err(rx_fram_err), .rx_ready(rx_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rint(rint), .miss(miss)
  );

  logic [7:0] bm [0:4095];
  logic [7:0] em [0:4095];

  // host memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) bm[{mem_addr[11:1], 1'b0}] = mem_wdata[7:0];
        if (mem_be[1]) bm[{mem_addr[11:1], 1'b1}] = mem_wdata[15:8];
      end else begin
        mem_rdata <= {bm[{mem_addr[11:1], 1'b1}], bm[{mem_addr[11:1], 1'b0}]};
      end
    end
  end

  typedef struct {
    int    didx;
    int    flags;
    int    mlen;
    int    nbytes;
    bit    last;
    string req;
  } item_t;

  item_t q[$];
  item_t it;
  int nchk = 0, nerr = 0, rint_cnt = 0, miss_cnt = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot(int i);
    return 32'h100 + 8 * i;
  endfunction

  task automatic arm(int i, int cap);
    int b, bl;
    b  = slot(i);
    bl = 32'hF000 | ((-cap) & 32'hFFF);
    bm[b]   = 8'(32'h400 + 32'h40 * i);
    bm[b+1] = 8'((32'h400 + 32'h40 * i) >> 8);
    bm[b+2] = 8'h00;
    bm[b+3] = 8'h80;
    bm[b+4] = 8'(bl);
    bm[b+5] = 8'(bl >> 8);
    bm[b+6] = 8'h00;
    bm[b+7] = 8'h00;
  endtask

  task automatic expect_desc(int didx, int flags, int mlen, int seed, int foff,
                             int nbytes, bit last, string req);
    item_t e;
    int b;
    b = 32'h400 + 32'h40 * didx;
    for (int k = 0; k < nbytes; k++) em[b+k] = 8'(seed + foff + k);
    e.didx = didx; e.flags = flags; e.mlen = mlen; e.nbytes = nbytes;
    e.last = last; e.req = req;
    q.push_back(e);
  endtask

  task automatic check_item(item_t e);
    int b, bufa, ml, bad;
    b    = slot(e.didx);
    bufa = {bm[b+1], bm[b]};
    chk(int'(bm[b+3]) == e.flags, e.req, "flag byte", int'(bm[b+3]), e.flags);
    if (e.mlen >= 0) begin
      ml = {bm[b+7], bm[b+6]};
      chk(ml == e.mlen, "R3", "message length", ml, e.mlen);
    end
    bad = 0;
    for (int k = 0; k < e.nbytes; k++) if (bm[(bufa + k) & 12'hFFF] !== em[(bufa + k) & 12'hFFF]) bad++;
    chk(bad == 0, "R4", "buffer byte mismatches", bad, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rint) begin
        bit done;
        rint_cnt++;
        done = 1'b0;
        while (!done) begin
          if (q.size() == 0) begin
            chk(1'b0, "R10", "rint with nothing pending", 1, 0);
            done = 1'b1;
          end else begin
            it = q.pop_front();
            check_item(it);
            done = it.last;
          end
        end
      end
      if (miss) miss_cnt++;
    end
  end

  task automatic send_frame(int n, int seed, bit crc, bit fram);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid    = 1'b1;
      rx_data     = 8'(seed + k);
      rx_last     = (k == n - 1);
      rx_crc_err  = crc && (k == n - 1);
      rx_fram_err = fram && (k == n - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_fram_err = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin bm[i] = 8'h00; em[i] = 8'h00; end
    for (int i = 0; i < 4; i++) arm(i, 16);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(rx_ready == 1'b0, "R1", "rx_ready after reset", rx_ready, 0);
    chk(rint == 1'b0, "R1", "rint after reset", rint, 0);
    chk(miss == 1'b0, "R1", "miss after reset", miss, 0);
    chk(mem_en == 1'b0, "R1", "mem_en after reset", mem_en, 0);

    // single buffer frame into slot 0 (R1, R3)
    expect_desc(0, 8'h03, 6, 8'h10, 0, 6, 1'b1, "R3");
    send_frame(6, 8'h10, 1'b0, 1'b0);
    chk({bm[slot(0)+5], bm[slot(0)+4]} == 16'hFFF0, "R2", "capacity word kept",
        {bm[slot(0)+5], bm[slot(0)+4]}, 16'hFFF0);
    chk({bm[slot(0)+1], bm[slot(0)]} == 16'h0400, "R2", "buffer address kept",
        {bm[slot(0)+1], bm[slot(0)]}, 16'h0400);

    // frame-check error (R5, R11)
    expect_desc(1, 8'h4B, 5, 8'h30, 0, 5, 1'b1, "R5");
    send_frame(5, 8'h30, 1'b1, 1'b0);

    // chained frame with error only in last slot (R6)
    expect_desc(2, 8'h02, -1, 8'h50, 0, 16, 1'b0, "R6");
    expect_desc(3, 8'h49, 20, 8'h50, 16, 4, 1'b1, "R6");
    send_frame(20, 8'h50, 1'b1, 1'b0);
    chk(rint_cnt == 3, "R10", "rint count", rint_cnt, 3);

    // index wrapped to slot 0 which host still holds (R8)
    send_frame(7, 8'h70, 1'b0, 1'b0);
    chk(miss_cnt == 1, "R8", "miss count", miss_cnt, 1);
    chk(rint_cnt == 3, "R8", "no rint on missed frame", rint_cnt, 3);
    chk(bm[slot(0)+3] == 8'h03, "R8", "slot 0 flag untouched", bm[slot(0)+3], 8'h03);

    arm(0, 16);
    arm(1, 16);
    // framing error lands in slot 0: index wrapped and held (R7, R11)
    expect_desc(0, 8'h63, 4, 8'h90, 0, 4, 1'b1, "R7");
    send_frame(4, 8'h90, 1'b0, 1'b1);

    // chaining into host-owned slot 2 truncates (R9, R11)
    expect_desc(1, 8'h57, 16, 8'hA0, 0, 16, 1'b1, "R9");
    send_frame(24, 8'hA0, 1'b0, 1'b0);

    arm(2, 16);
    arm(3, 16);
    expect_desc(2, 8'h03, 3, 8'hC0, 0, 3, 1'b1, "R9");
    send_frame(3, 8'hC0, 1'b0, 1'b0);
    chk(bm[slot(3)+3] == 8'h80, "R9", "slot 3 still engine-owned", bm[slot(3)+3], 8'h80);
    chk(miss_cnt == 1, "R9", "overflow is not a miss", miss_cnt, 1);
    chk(rint_cnt == 6, "R10", "rint count at end", rint_cnt, 6);
    chk(rx_ready == 1'b0, "R12", "rx_ready low when idle", rx_ready, 0);
    chk(q.size() == 0, "R10", "pending expected items", q.size(), 0);

    summary();
    $finish;
  end
endmodule